// File: doc/BRIEF.md
# Six-Lane Dot Sequencer

This block turns a serial stream of pixel codes, one per dot period, into six parallel hold registers that feed a column driver. It runs on a clock at twice the dot rate, so a half dot period is one tick. A pixel is taken on every second tick. The falling edge of a line sync input restarts the sequence. Retained pixels fill a staging row in rotation. When the row is full, it is copied into one of two snapshot buffers. A delayed load strobe then moves the snapshot into the six lane registers.

At each line start the block takes in its settings: lane order (rising or falling), single or shared operation, which half of the stream to keep when shared, whether the two lane halves load together or one tick apart, and a 4-bit phase delay. In shared operation two such blocks see the same stream and each keeps every second pixel. The phase delay moves the lane loads later by whole ticks in single operation and by pairs of ticks in shared operation. Each lane carries a sticky valid flag and a one-tick load strobe.

Top module: `vid_demux6`

## Requirements
- R1: While reset is asserted and directly after it, every lane output, every valid flag and every strobe reads 0.
- R2: The tick at which `line_sync` is first seen low after being high is the restart tick. Pixel number k (k = 1, 2, ...) is the value on `pix_in` at the clock edge 2k-1 ticks after the restart tick.
- R3: Before the first falling edge of `line_sync`, no lane loads, whatever `pix_in` carries.
- R4: With `scan_up` = 1, the j-th retained pixel of a row (j = 0..5) goes to lane j+1. With `scan_up` = 0, it goes to lane 6-j. Lane n sits at `lane_data[n*DW-1 -: DW]`.
- R5: With `dual_mode` = 0, every pixel is retained. With `dual_mode` = 1, only even-numbered pixels are retained when `take_odd` = 0, and only odd-numbered pixels when `take_odd` = 1.
- R6: With `split_groups` = 0, all six lanes load and strobe on the same tick. That tick is D+1 ticks after the edge that retained the sixth pixel of the row.
- R7: With `split_groups` = 1, lanes 1-3 load at that tick and lanes 4-6 load one tick later.
- R8: The delay D is the phase value p (0..15) in single operation and 2p in shared operation.
- R9: A lane changes only on a tick where its strobe is 1. A strobe lasts one tick. A valid flag rises with the first load of its lane and then stays at 1 until reset.
- R10: Order, mode, role, grouping and phase are taken in at the restart tick. Changes to them during the line have no effect until the next restart.
- R11: A restart throws away a partly filled row and every load still waiting. No strobe appears on the tick after a restart, and the lanes keep their values.
- R12: At phase 15, rows that follow back to back still reach the lanes intact, in both single and shared operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the dot rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_sync | input | 1 | Line sync; its falling edge restarts the sequence |
| pix_in | input | DW | Pixel code, changed once per dot period |
| scan_up | input | 1 | 1: rising lane order, 0: falling lane order |
| dual_mode | input | 1 | 1: shared operation, keep every second pixel |
| take_odd | input | 1 | In shared operation, 1 keeps odd pixels and 0 keeps even pixels |
| split_groups | input | 1 | 1: lanes 4-6 load one tick after lanes 1-3 |
| phase_sel | input | PH_W | Output delay setting |
| lane_data | output | LANES*DW | Lane hold registers; lane 1 in the low bits |
| lane_valid | output | LANES | Sticky flag per lane: the lane has been loaded |
| lane_strobe | output | LANES | One-tick pulse on the tick a lane loads |

## Verification
A restart can land in the same tick as a pending lane load, or between the two halves of a split load. In that case the restart must win, and the lanes must keep the older row. The bench provokes this by ending a line at phase 15 after a row has completed but before its delayed strobe comes due. It then starts a new line and checks, tick by tick, that the lanes keep the older contents until the new line's own rows arrive. A second overlap occurs when one row completes while the previous row's delayed load is still pending. This is driven at phase 15 in both modes, and each lane is compared against the values the bench computes for each row.

// File: rtl/dmx6_pkg.sv
`timescale 1ns/1ps
package dmx6_pkg;

   // Settings taken in at each line restart.
   typedef struct packed {
      logic dual;      // shared operation: keep every second pixel
      logic keep_odd;  // shared operation: keep odd-numbered pixels
      logic up;        // rising lane order
      logic split;     // upper half of the lanes loads one tick later
   } dmx_cfg_t;

   // Lane index for a fill position in the staging row.
   function automatic int unsigned slot_to_lane(input int unsigned slot,
                                                input logic up,
                                                input int unsigned lanes);
      return up ? slot : (lanes - 1 - slot);
   endfunction

endpackage

// File: rtl/dmx_sync_ctl.sv
`timescale 1ns/1ps
module dmx_sync_ctl
   import dmx6_pkg::*;
#(
   parameter int PH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            line_sync,
   input  dmx_cfg_t        cfg_in,
   input  logic [PH_W-1:0] ph_in,
   output logic            restart,
   output logic            cap,
   output dmx_cfg_t        cfg_q,
   output logic [PH_W-1:0] ph_q
);

   logic sync_q;
   logic armed;
   logic half;

   // High-to-low transition of the line sync seen this tick.
   assign restart = sync_q & ~line_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         armed  <= 1'b0;
         half   <= 1'b0;
         cfg_q  <= '0;
         ph_q   <= '0;
      end else begin
         sync_q <= line_sync;
         if (restart) begin
            armed <= 1'b1;
            half  <= 1'b0;
            cfg_q <= cfg_in;
            ph_q  <= ph_in;
         end else if (armed) begin
            half <= ~half;
         end
      end
   end

   // A pixel is taken on the first tick after a restart and on every second tick after that.
   assign cap = armed & ~half & ~restart;

endmodule

// File: rtl/dmx_packer.sv
`timescale 1ns/1ps
module dmx_packer
   import dmx6_pkg::*;
#(
   parameter int LANES = 6,
   parameter int DW    = 10
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            restart,
   input  logic                            cap,
   input  dmx_cfg_t                        cfg,
   input  logic [DW-1:0]                   pix,
   output logic                            done,
   output logic                            wr_tag,
   output logic [1:0][LANES-1:0][DW-1:0]   snap
);

   localparam int SLOT_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LANES - 1);

   logic                       odd_nxt;
   logic [SLOT_W-1:0]          slot;
   logic [SLOT_W-1:0]          lane_idx;
   logic [LANES-1:0][DW-1:0]   stage;
   logic [LANES-1:0][DW-1:0]   stage_nx;
   logic                       wr_sel;
   logic                       keep;

   assign keep     = cap & (~cfg.dual | (odd_nxt == cfg.keep_odd));
   assign lane_idx = SLOT_W'(slot_to_lane(32'(slot), cfg.up, LANES));
   assign done     = keep & (slot == LAST_SLOT);
   assign wr_tag   = wr_sel;

   always_comb begin
      stage_nx = stage;
      if (keep) stage_nx[lane_idx] = pix;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odd_nxt <= 1'b1;
         slot    <= '0;
         stage   <= '0;
         snap    <= '0;
         wr_sel  <= 1'b0;
      end else if (restart) begin
         odd_nxt <= 1'b1;
         slot    <= '0;
      end else begin
         if (cap) odd_nxt <= ~odd_nxt;
         if (keep) begin
            stage <= stage_nx;
            slot  <= done ? '0 : slot + 1'b1;
         end
         if (done) begin
            snap[wr_sel] <= stage_nx;
            wr_sel       <= ~wr_sel;
         end
      end
   end

endmodule

// File: rtl/dmx_strobe_dly.sv
`timescale 1ns/1ps
module dmx_strobe_dly #(
   parameter int PH_W   = 4,
   parameter int STEP_S = 1,
   parameter int STEP_D = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            done,
   input  logic            wr_tag,
   input  logic            dual,
   input  logic            split,
   input  logic [PH_W-1:0] ph,
   output logic            ld_lo,
   output logic            ld_hi,
   output logic            tag_lo,
   output logic            tag_hi
);

   localparam int PH_MAX = (1 << PH_W) - 1;
   localparam int STEP_M = (STEP_D > STEP_S) ? STEP_D : STEP_S;
   localparam int MAX_D  = PH_MAX * STEP_M;
   localparam int N      = MAX_D + 2;
   localparam int DLY_W  = $clog2(N);

   logic [N-1:0]     pv;
   logic [N-1:0]     pt;
   logic [DLY_W-1:0] dly;
   logic [DLY_W-1:0] hi_idx;

   always_comb begin
      dly    = DLY_W'(int'(ph) * (dual ? STEP_D : STEP_S));
      hi_idx = split ? DLY_W'(dly + 1'b1) : dly;
   end

   assign ld_lo  = pv[dly] & ~restart;
   assign tag_lo = pt[dly];
   assign ld_hi  = pv[hi_idx] & ~restart;
   assign tag_hi = pt[hi_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv <= '0;
         pt <= '0;
      end else if (restart) begin
         pv <= '0;
         pt <= '0;
      end else begin
         pv <= {pv[N-2:0], done};
         pt <= {pt[N-2:0], wr_tag};
      end
   end

endmodule

// File: rtl/dmx_lane_bank.sv
`timescale 1ns/1ps
module dmx_lane_bank #(
   parameter int LANES = 6,
   parameter int DW    = 10
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ld_lo,
   input  logic                            ld_hi,
   input  logic                            tag_lo,
   input  logic                            tag_hi,
   input  logic [1:0][LANES-1:0][DW-1:0]   snap,
   output logic [LANES*DW-1:0]             lane_data,
   output logic [LANES-1:0]                lane_valid,
   output logic [LANES-1:0]                lane_strobe
);

   localparam int LO_N = LANES / 2;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic          ld;
      logic          tg;
      logic [DW-1:0] q;
      logic          v;
      logic          s;

      if (i < LO_N) begin : g_lo
         assign ld = ld_lo;
         assign tg = tag_lo;
      end else begin : g_hi
         assign ld = ld_hi;
         assign tg = tag_hi;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
            v <= 1'b0;
            s <= 1'b0;
         end else begin
            s <= ld;
            if (ld) begin
               q <= snap[tg][i];
               v <= 1'b1;
            end
         end
      end

      assign lane_data[i*DW +: DW] = q;
      assign lane_valid[i]         = v;
      assign lane_strobe[i]        = s;
   end

endmodule

// File: rtl/vid_demux6.sv
`timescale 1ns/1ps
module vid_demux6
   import dmx6_pkg::*;
#(
   parameter int LANES  = 6,
   parameter int DW     = 10,
   parameter int PH_W   = 4,
   parameter int STEP_S = 1,
   parameter int STEP_D = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_sync,
   input  logic [DW-1:0]        pix_in,
   input  logic                 scan_up,
   input  logic                 dual_mode,
   input  logic                 take_odd,
   input  logic                 split_groups,
   input  logic [PH_W-1:0]      phase_sel,
   output logic [LANES*DW-1:0]  lane_data,
   output logic [LANES-1:0]     lane_valid,
   output logic [LANES-1:0]     lane_strobe
);

   localparam int PH_MAX     = (1 << PH_W) - 1;
   localparam int ROW_TICK_S = 2 * LANES;
   localparam int ROW_TICK_D = 4 * LANES;

   // Parameter checks at elaboration.
   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("vid_demux6: LANES must be even and at least 2");
   end
   if (PH_MAX * STEP_S + 2 >= 2 * ROW_TICK_S) begin : g_bad_single
      $error("vid_demux6: single-mode delay overruns the two snapshot buffers");
   end
   if (PH_MAX * STEP_D + 2 >= 2 * ROW_TICK_D) begin : g_bad_dual
      $error("vid_demux6: shared-mode delay overruns the two snapshot buffers");
   end

   dmx_cfg_t                        cfg_in;
   dmx_cfg_t                        cfg_q;
   logic [PH_W-1:0]                 ph_q;
   logic                            restart;
   logic                            cap;
   logic                            done;
   logic                            wr_tag;
   logic [1:0][LANES-1:0][DW-1:0]   snap;
   logic                            ld_lo;
   logic                            ld_hi;
   logic                            tag_lo;
   logic                            tag_hi;
   logic                            cfg_split;

   assign cfg_in    = '{dual: dual_mode, keep_odd: take_odd, up: scan_up, split: split_groups};
   assign cfg_split = cfg_q.split;

   dmx_sync_ctl #(.PH_W(PH_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_sync(line_sync),
      .cfg_in  (cfg_in),
      .ph_in   (phase_sel),
      .restart (restart),
      .cap     (cap),
      .cfg_q   (cfg_q),
      .ph_q    (ph_q)
   );

   dmx_packer #(.LANES(LANES), .DW(DW)) u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .cap    (cap),
      .cfg    (cfg_q),
      .pix    (pix_in),
      .done   (done),
      .wr_tag (wr_tag),
      .snap   (snap)
   );

   dmx_strobe_dly #(.PH_W(PH_W), .STEP_S(STEP_S), .STEP_D(STEP_D)) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .done   (done),
      .wr_tag (wr_tag),
      .dual   (cfg_q.dual),
      .split  (cfg_q.split),
      .ph     (ph_q),
      .ld_lo  (ld_lo),
      .ld_hi  (ld_hi),
      .tag_lo (tag_lo),
      .tag_hi (tag_hi)
   );

   dmx_lane_bank #(.LANES(LANES), .DW(DW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_lo      (ld_lo),
      .ld_hi      (ld_hi),
      .tag_lo     (tag_lo),
      .tag_hi     (tag_hi),
      .snap       (snap),
      .lane_data  (lane_data),
      .lane_valid (lane_valid),
      .lane_strobe(lane_strobe)
   );

endmodule

// File: rtl/dmx_checker.sv
`timescale 1ns/1ps
module dmx_checker #(
   parameter int LANES = 6,
   parameter int DW    = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                restart,
   input logic                cfg_split,
   input logic [LANES*DW-1:0] lane_data,
   input logic [LANES-1:0]    lane_valid,
   input logic [LANES-1:0]    lane_strobe
);

   localparam int LO_N = LANES / 2;
   localparam int HI_N = LANES - LO_N;

   logic [LO_N-1:0] lo_s;
   logic [HI_N-1:0] hi_s;
   assign lo_s = lane_strobe[LO_N-1:0];
   assign hi_s = lane_strobe[LANES-1:LO_N];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // R9
      lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !lane_strobe[i] |-> $stable(lane_data[i*DW +: DW]));
      // R9
      strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lane_strobe[i] |-> lane_valid[i]);
   end

   // R9
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lane_valid & $past(lane_valid)) == $past(lane_valid)));

   // R6
   group_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(lo_s) == 0 || $countones(lo_s) == LO_N) &&
      ($countones(hi_s) == 0 || $countones(hi_s) == HI_N));

   // R6
   joint_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_split |-> ((|lo_s) == (|hi_s)));

   // R7
   skew_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_split && (|lo_s) && !restart) |=> (|hi_s));

   // R11
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (lane_strobe == '0));

endmodule

bind vid_demux6 dmx_checker #(.LANES(LANES), .DW(DW)) i_dmx_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .restart    (restart),
   .cfg_split  (cfg_split),
   .lane_data  (lane_data),
   .lane_valid (lane_valid),
   .lane_strobe(lane_strobe)
);

// File: tb/test_vid_demux6.sv
`timescale 1ns/1ps
module test_vid_demux6;

   localparam int LANES = 6;
   localparam int DW    = 10;
   localparam int PH_W  = 4;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                line_sync;
   logic [DW-1:0]       pix_in;
   logic                scan_up;
   logic                dual_mode;
   logic                take_odd;
   logic                split_groups;
   logic [PH_W-1:0]     phase_sel;
   logic [LANES*DW-1:0] lane_data;
   logic [LANES-1:0]    lane_valid;
   logic [LANES-1:0]    lane_strobe;

   int n_chk = 0;
   int n_bad = 0;
   bit fin   = 1'b0;

   logic [LANES*DW-1:0] exp_d;
   logic [LANES-1:0]    exp_v;
   logic [LANES-1:0]    exp_s;

   always #4 clk = ~clk;

   vid_demux6 #(.LANES(LANES), .DW(DW), .PH_W(PH_W)) i_vid_demux6 (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_sync   (line_sync),
      .pix_in      (pix_in),
      .scan_up     (scan_up),
      .dual_mode   (dual_mode),
      .take_odd    (take_odd),
      .split_groups(split_groups),
      .phase_sel   (phase_sel),
      .lane_data   (lane_data),
      .lane_valid  (lane_valid),
      .lane_strobe (lane_strobe)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic compare(input string tag, input int n);
      n_chk++;
      if (lane_data !== exp_d || lane_valid !== exp_v || lane_strobe !== exp_s) begin
         n_bad++;
         $display("FAIL %s tick %0d: data=%h valid=%b strobe=%b expected data=%h valid=%b strobe=%b",
                  tag, n, lane_data, lane_valid, lane_strobe, exp_d, exp_v, exp_s);
      end
   endtask

   function automatic int kept_k(input int j, input bit dual, input bit odd);
      if (!dual) return j + 1;
      return odd ? (2 * j + 1) : (2 * j + 2);
   endfunction

   function automatic logic [DW-1:0] val(input int base, input int k);
      return DW'(base + 7 * k);
   endfunction

   // One line: restart, then nedge ticks checked against the computed lane contents.
   task automatic run_line(input string tag, input bit dual, input bit odd, input bit up,
                           input bit split, input int ph, input int base, input int nedge,
                           input bit scramble);
      int d;
      d = dual ? 2 * ph : ph;
      dual_mode    = dual;
      take_odd     = odd;
      scan_up      = up;
      split_groups = split;
      phase_sel    = PH_W'(ph);
      line_sync    = 1'b0;
      pix_in       = val(base, 1);
      tick();                      // restart tick (R2)
      if (scramble) begin          // R10: live settings flipped after the restart tick
         dual_mode    = ~dual;
         take_odd     = ~odd;
         scan_up      = ~up;
         split_groups = ~split;
         phase_sel    = ~PH_W'(ph);
      end
      for (int n = 1; n <= nedge; n++) begin
         tick();
         exp_s = '0;
         for (int g = 0; g < 16; g++) begin
            int ec;
            int lo_n;
            int hi_n;
            ec   = 2 * kept_k(LANES * g + LANES - 1, dual, odd) - 1;
            lo_n = ec + d + 1;
            hi_n = lo_n + (split ? 1 : 0);
            for (int l = 0; l < LANES; l++) begin
               if ((l < LANES / 2 && n == lo_n) || (l >= LANES / 2 && n == hi_n)) begin
                  exp_d[l*DW +: DW] = val(base, kept_k(LANES * g + (up ? l : LANES - 1 - l), dual, odd));
                  exp_v[l] = 1'b1;
                  exp_s[l] = 1'b1;
               end
            end
         end
         compare(tag, n);
         if (n % 2 == 0) pix_in = val(base, n / 2 + 1);
         if (n == nedge - 1) line_sync = 1'b1;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      line_sync = 1'b1;
      pix_in = '0;
      scan_up = 1'b1;
      dual_mode = 1'b0;
      take_odd = 1'b0;
      split_groups = 1'b0;
      phase_sel = '0;
      exp_d = '0;
      exp_v = '0;
      exp_s = '0;
      tick();
      tick();
      compare("R1 in reset", 0);
      rst_n = 1'b1;
      tick();
      compare("R1 after reset", 1);
   endtask

   task automatic t_idle();
      for (int n = 0; n < 40; n++) begin
         pix_in = DW'(n * 37 + 5);
         phase_sel = PH_W'(n);
         tick();
         compare("R3 idle before first sync fall", n);
      end
      phase_sel = '0;
   endtask

   initial begin
      t_reset();
      t_idle();
      run_line("R2 R3 R6 single rising phase 0", 1'b0, 1'b0, 1'b1, 1'b0, 0, 16, 50, 1'b0);
      run_line("R4 R7 R8 single falling phase 3 split", 1'b0, 1'b0, 1'b0, 1'b1, 3, 100, 50, 1'b0);
      run_line("R5 shared even rising", 1'b1, 1'b0, 1'b1, 1'b0, 0, 200, 60, 1'b0);
      run_line("R5 R8 shared odd falling phase 5 split", 1'b1, 1'b1, 1'b0, 1'b1, 5, 300, 70, 1'b0);
      run_line("R12 shared even rising phase 15 split", 1'b1, 1'b0, 1'b1, 1'b1, 15, 400, 110, 1'b0);
      run_line("R12 single falling phase 15 split", 1'b0, 1'b0, 1'b0, 1'b1, 15, 500, 60, 1'b0);
      run_line("R10 settings changed mid line", 1'b0, 1'b0, 1'b1, 1'b0, 2, 600, 40, 1'b1);
      run_line("R11 line cut before delayed load", 1'b0, 1'b0, 1'b1, 1'b1, 15, 700, 20, 1'b0);
      run_line("R11 lanes kept after restart", 1'b1, 1'b1, 1'b1, 1'b0, 1, 800, 40, 1'b0);
      fin = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!fin) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule